// File: doc/BRIEF.md
# Serial DMA Request Decoder

This block is the host-side receiver for a single active-low serial DMA request line. One peripheral owns the line and drives it in step with the bus clock. A message is a low start bit, then a three-bit channel number sent most significant bit first, then an activity bit. After the message the line must rest high before the next start. The decoder frames each message, extracts the channel and the activity bit, and keeps an eight-bit register of pending channel requests for a downstream DMA arbiter.

A message whose activity bit is 1 raises the channel's pending bit. A message whose activity bit is 0 withdraws the request: the bit is cleared and a one-clock withdrawal pulse carries the channel number. A grant the arbiter has already issued is not cancelled by this, so the transfer may still run. The DMA engine clears a bit with a transfer-done strobe when it finishes a transfer. If the line is low in the clock where the rest bit belongs, the message is discarded as a framing error.

Top module: `dreq_serial_decoder`

## Requirements
- R1: While `rst` is sampled high, and in the clock after it falls, `req_pend` is all zero, `msg_valid`, `wd_pulse` and `frame_err` are low, and the decoder waits for a start bit.
- R2: While the decoder is idle, a high sample on `dreq_n` starts nothing: no pulse is output and `req_pend` keeps its value unless `xfer_done` clears a bit.
- R3: Number the sampled clocks of a message 1 (the low start bit) to 6 (the rest bit). Samples 2, 3 and 4 are the line levels of channel bits 2, 1 and 0 (high = 1). When sample 6 is high, `msg_valid` is high for exactly the one clock after that edge, with `msg_chan` equal to the channel and `msg_act` equal to sample 5.
- R4: A completed message with activity bit 1 sets `req_pend[channel]` in the same clock that `msg_valid` rises.
- R5: A completed message with activity bit 0 clears `req_pend[channel]` and raises `wd_pulse` for that one clock with `wd_chan` equal to the channel. This happens whether or not the bit was set.
- R6: A low level at sample 6 raises `frame_err` for one clock. `msg_valid` and `wd_pulse` stay low, and `req_pend` is not changed by that message.
- R7: After a framing error the decoder takes no start bit until it has seen a high sample, so a line held low does not begin a new message.
- R8: A start bit in the clock right after a good rest bit is accepted, so messages may follow each other at six-clock spacing.
- R9: `xfer_done` high at an edge clears `req_pend[xfer_chan]`. If a completed message with activity bit 1 sets the same channel at the same edge, the bit ends up set.
- R10: A pending bit that neither a completed message nor `xfer_done` addresses keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; `dreq_n` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dreq_n | input | 1 | Serial request line from the peripheral, idles high |
| xfer_done | input | 1 | Transfer-finished strobe from the DMA engine |
| xfer_chan | input | 3 | Channel whose pending bit `xfer_done` clears |
| req_pend | output | 8 | Pending request per channel, bit index = channel |
| msg_valid | output | 1 | One-clock pulse per completed message |
| msg_chan | output | 3 | Channel of the completed message |
| msg_act | output | 1 | Activity bit of the completed message |
| wd_pulse | output | 1 | One-clock pulse when a request is withdrawn |
| wd_chan | output | 3 | Channel of the withdrawn request |
| frame_err | output | 1 | One-clock pulse when the rest bit after a message is low |

## Verification
The case that is hardest to reach from the ports is a set and a transfer-done clear for the same channel landing on the same edge. That edge is the rest-bit sample of a message, so the stimulus has to line up the clear strobe with the sixth clock of a frame. The bench does this directly, and random clears fired in any clock of long random message streams hit it again. Recovery after a framing error is reached by holding the line low through and past the rest slot for several clocks, then returning it high. The next message is then sent at once, which also covers the six-clock back-to-back spacing.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    // Channel field width of the serial message and the resulting channel count
    localparam int CHAN_W   = 3;
    localparam int NUM_CHAN = 1 << CHAN_W;

    typedef logic [CHAN_W-1:0]   chan_t;
    typedef logic [NUM_CHAN-1:0] chan_vec_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHAN    = 3'd1,
        ST_ACT     = 3'd2,
        ST_GAP     = 3'd3,
        ST_RECOVER = 3'd4
    } frm_state_t;

    // Outcome of the framer in the current clock
    typedef struct packed {
        logic  done;
        logic  bad;
        logic  act;
        chan_t chan;
    } frm_evt_t;

    function automatic chan_vec_t chan_onehot(input chan_t c);
        chan_vec_t v;
        v    = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dreq_framer.sv
module dreq_framer
    import dreq_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_n,
    output frm_evt_t evt
);

    localparam int CNT_W = (CHAN_W > 1) ? $clog2(CHAN_W) : 1;
    localparam int GAP_W = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

    frm_state_t        state;
    chan_t             shift_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              act_q;
    logic              gap_last;

    assign gap_last  = (gap_cnt == GAP_W'(GAP_CLKS - 1));

    always_comb begin
        evt.done = (state == ST_GAP) && line_n && gap_last;
        evt.bad  = (state == ST_GAP) && !line_n;
        evt.act  = act_q;
        evt.chan = shift_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shift_q <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
            act_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!line_n) begin
                        state   <= ST_CHAN;
                        bit_cnt <= '0;
                    end
                end
                ST_CHAN: begin
                    shift_q <= {shift_q[CHAN_W-2:0], line_n};
                    if (bit_cnt == CNT_W'(CHAN_W - 1)) begin
                        state <= ST_ACT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_ACT: begin
                    act_q   <= line_n;
                    gap_cnt <= '0;
                    state   <= ST_GAP;
                end
                ST_GAP: begin
                    if (!line_n) begin
                        state <= ST_RECOVER;
                    end else if (gap_last) begin
                        state <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (line_n) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && line_n) |=> (state == ST_IDLE));

    // R7
    recover_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && !line_n) |=> (state == ST_RECOVER));

    // R6
    bad_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        evt.bad |-> !evt.done);

endmodule

// File: rtl/dreq_req_bank.sv
module dreq_req_bank
    import dreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      msg_v,
    input  chan_t     msg_c,
    input  logic      msg_act,
    input  logic      fin_v,
    input  chan_t     fin_c,
    output chan_vec_t pending
);

    chan_vec_t msg_hit;
    chan_vec_t fin_hit;

    assign msg_hit = msg_v ? chan_onehot(msg_c) : '0;
    assign fin_hit = fin_v ? chan_onehot(fin_c) : '0;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pending[g] <= 1'b0;
            end else if (msg_hit[g]) begin
                pending[g] <= msg_act;
            end else if (fin_hit[g]) begin
                pending[g] <= 1'b0;
            end
        end

        // R10
        untouched_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !(msg_hit[g] || fin_hit[g]) |=> $stable(pending[g]));
    end

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_v && msg_act && fin_v && fin_c == msg_c) |=> pending[$past(msg_c)]);

    // R9
    fin_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fin_v && !(msg_v && msg_c == fin_c)) |=> !pending[$past(fin_c)]);

endmodule

// File: rtl/dreq_evt_stage.sv
module dreq_evt_stage
    import dreq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  frm_evt_t evt,
    output logic     msg_valid,
    output chan_t    msg_chan,
    output logic     msg_act,
    output logic     wd_pulse,
    output chan_t    wd_chan,
    output logic     frame_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_chan  <= '0;
            msg_act   <= 1'b0;
            wd_pulse  <= 1'b0;
            wd_chan   <= '0;
            frame_err <= 1'b0;
        end else begin
            msg_valid <= evt.done;
            wd_pulse  <= evt.done && !evt.act;
            frame_err <= evt.bad;
            if (evt.done) begin
                msg_chan <= evt.chan;
                msg_act  <= evt.act;
            end
            if (evt.done && !evt.act) begin
                wd_chan <= evt.chan;
            end
        end
    end

    // R3
    msg_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R6
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

endmodule

// File: rtl/dreq_serial_decoder.sv
module dreq_serial_decoder
    import dreq_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dreq_n,
    input  logic                xfer_done,
    input  logic [CHAN_W-1:0]   xfer_chan,
    output logic [NUM_CHAN-1:0] req_pend,
    output logic                msg_valid,
    output logic [CHAN_W-1:0]   msg_chan,
    output logic                msg_act,
    output logic                wd_pulse,
    output logic [CHAN_W-1:0]   wd_chan,
    output logic                frame_err
);

    frm_evt_t evt;

    dreq_framer #(
        .GAP_CLKS (GAP_CLKS)
    ) u_framer (
        .clk    (clk),
        .rst    (rst),
        .line_n (dreq_n),
        .evt    (evt)
    );

    dreq_req_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .msg_v   (evt.done),
        .msg_c   (evt.chan),
        .msg_act (evt.act),
        .fin_v   (xfer_done),
        .fin_c   (xfer_chan),
        .pending (req_pend)
    );

    dreq_evt_stage u_evt (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .msg_valid (msg_valid),
        .msg_chan  (msg_chan),
        .msg_act   (msg_act),
        .wd_pulse  (wd_pulse),
        .wd_chan   (wd_chan),
        .frame_err (frame_err)
    );

    // R4
    set_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_act) |-> req_pend[msg_chan]);

    // R5
    withdraw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wd_pulse |-> (msg_valid && !msg_act && wd_chan == msg_chan && !req_pend[wd_chan]));

    // R6
    err_excludes_msg_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !(msg_valid || wd_pulse));

endmodule

// File: tb/test_dreq_serial_decoder.sv
module test_dreq_serial_decoder;

    localparam time CLK_PER = 4ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       dreq_n;
    logic       xfer_done;
    logic [2:0] xfer_chan;
    logic [7:0] req_pend;
    logic       msg_valid;
    logic [2:0] msg_chan;
    logic       msg_act;
    logic       wd_pulse;
    logic [2:0] wd_chan;
    logic       frame_err;

    int checks   = 0;
    int failures = 0;

    logic [7:0] e_pend;
    logic       e_mv, e_ma, e_wd, e_fe;
    logic [2:0] e_mc;
    string      prev_tag;
    logic       force_v;
    logic [2:0] force_c;
    logic       rand_en;

    always #(CLK_PER/2) clk = ~clk;

    dreq_serial_decoder i_dreq_serial_decoder (
        .clk       (clk),
        .rst       (rst),
        .dreq_n    (dreq_n),
        .xfer_done (xfer_done),
        .xfer_chan (xfer_chan),
        .req_pend  (req_pend),
        .msg_valid (msg_valid),
        .msg_chan  (msg_chan),
        .msg_act   (msg_act),
        .wd_pulse  (wd_pulse),
        .wd_chan   (wd_chan),
        .frame_err (frame_err)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "req_pend", req_pend, e_pend);
        chk(tag, "msg_valid", {7'd0, msg_valid}, {7'd0, e_mv});
        chk(tag, "wd_pulse", {7'd0, wd_pulse}, {7'd0, e_wd});
        chk(tag, "frame_err", {7'd0, frame_err}, {7'd0, e_fe});
        if (e_mv) begin
            chk(tag, "msg_chan", {5'd0, msg_chan}, {5'd0, e_mc});
            chk(tag, "msg_act", {7'd0, msg_act}, {7'd0, e_ma});
        end
        if (e_wd) chk(tag, "wd_chan", {5'd0, wd_chan}, {5'd0, e_mc});
    endtask

    // One bus clock: check results of the previous edge, drive this one, predict it
    task automatic cyc(input logic ln, input logic done, input logic bad,
                       input logic [2:0] ch, input logic act, input string tag);
        logic       fv;
        logic [2:0] fc;
        @(negedge clk);
        compare_all(prev_tag);
        fv = 1'b0;
        fc = 3'd0;
        if (force_v) begin
            fv = 1'b1; fc = force_c; force_v = 1'b0;
        end else if (rand_en && ($urandom % 4 == 0)) begin
            fv = 1'b1; fc = 3'($urandom % 8);
        end
        dreq_n    = ln;
        xfer_done = fv;
        xfer_chan = fc;
        if (fv)   e_pend[fc] = 1'b0;
        if (done) e_pend[ch] = act;   // set from a message wins over the clear
        e_mv = done;
        e_mc = ch;
        e_ma = act;
        e_wd = done && !act;
        e_fe = bad;
        prev_tag = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, tag);
    endtask

    // good=0: low in the rest slot, then hold low for 'hold' clocks and return high
    task automatic send_frame(input logic [2:0] ch, input logic act, input logic good,
                              input int hold, input logic clr_v, input logic [2:0] clr_c,
                              input string tag);
        cyc(1'b0, 1'b0, 1'b0, ch, act, tag);
        for (int b = 2; b >= 0; b--) cyc(ch[b], 1'b0, 1'b0, ch, act, tag);
        cyc(act, 1'b0, 1'b0, ch, act, tag);
        if (clr_v) begin force_v = 1'b1; force_c = clr_c; end
        if (good) begin
            cyc(1'b1, 1'b1, 1'b0, ch, act, tag);
        end else begin
            cyc(1'b0, 1'b0, 1'b1, ch, act, tag);
            for (int h = 0; h < hold; h++) cyc(1'b0, 1'b0, 1'b0, ch, act, tag);
            cyc(1'b1, 1'b0, 1'b0, ch, act, tag);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst = 1'b1; dreq_n = 1'b1; xfer_done = 1'b0; xfer_chan = 3'd0;
        force_v = 1'b0; force_c = 3'd0; rand_en = 1'b0;
        e_pend = 8'h00; e_mv = 0; e_ma = 0; e_wd = 0; e_fe = 0; e_mc = 0;
        prev_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");     // R1: state while reset is held
        rst = 1'b0;
        idle(1, "R1");         // R1: first clock out of reset

        // R2: idle line does nothing
        idle(6, "R2");

        // R3 / R4: channel order and setting
        send_frame(3'd5, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R4");
        idle(2, "R4");
        send_frame(3'd6, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R3");
        idle(1, "R3");
        send_frame(3'd1, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R3");
        idle(1, "R10");

        // R5: withdrawal of a set and of an unset channel
        send_frame(3'd5, 1'b0, 1'b1, 0, 1'b0, 3'd0, "R5");
        idle(1, "R5");
        send_frame(3'd2, 1'b0, 1'b1, 0, 1'b0, 3'd0, "R5");
        idle(2, "R5");

        // R6 / R7: framing error, then line held low with no new start
        send_frame(3'd3, 1'b1, 1'b0, 0, 1'b0, 3'd0, "R6");
        idle(1, "R6");
        send_frame(3'd4, 1'b1, 1'b0, 7, 1'b0, 3'd0, "R7");
        send_frame(3'd7, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R7");

        // R8: back-to-back messages
        send_frame(3'd0, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R8");
        send_frame(3'd3, 1'b1, 1'b1, 0, 1'b0, 3'd0, "R8");
        send_frame(3'd7, 1'b0, 1'b1, 0, 1'b0, 3'd0, "R8");
        idle(1, "R8");

        // R9: simultaneous set and clear of one channel, then plain clear
        send_frame(3'd4, 1'b1, 1'b1, 0, 1'b1, 3'd4, "R9");
        idle(1, "R9");
        force_v = 1'b1; force_c = 3'd4;
        idle(2, "R9");
        send_frame(3'd2, 1'b1, 1'b1, 0, 1'b1, 3'd6, "R9");
        idle(1, "R9");

        // Random stream with random clears in any clock
        rand_en = 1'b1;
        for (int m = 0; m < 400; m++) begin
            logic [2:0] ch;
            logic       act;
            logic       good;
            ch   = 3'($urandom % 8);
            act  = ($urandom % 3) != 0;
            good = ($urandom % 10) != 0;
            send_frame(ch, act, good, int'($urandom % 3), ($urandom % 8) == 0, 3'($urandom % 8),
                       good ? (act ? "R4" : "R5") : "R6");
            idle(int'($urandom % 4), "R10");
        end
        rand_en = 1'b0;
        idle(2, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule